// File: doc/BRIEF.md
# Multi-Channel ADC Sample Sequencer

This block runs a successive-approximation converter through a programmable list of up to eight channel slots. Once software has set the enable level and fires a start pulse, the sequencer visits slot 0, slot 1 and onwards up to a programmable last slot. Before each conversion it holds off for a programmable settling delay. It then asks the converter for a sample over a request/acknowledge handshake, and writes the returned code, tagged with the channel number of that slot, into a 32-word result FIFO.

The run either ends after one pass or wraps back to slot 0 and repeats until a stop pulse arrives. A stop that lands while a conversion is outstanding keeps the block busy until the converter acknowledges, and that late result is thrown away. The FIFO reports its occupancy, full and empty state, and a sticky flag for lost results. An interrupt line rises while the occupancy is at or above a programmable level.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the block is idle: `busy`, `conv_req`, `irq` and `fifo_overflow` are 0, `fifo_empty` is 1 and `fifo_count` is 0.
- R2: A `start` pulse begins a run only while `cfg_enable` is 1 and the block is idle. Otherwise it leaves `busy` at 0.
- R3: Each settling wait lasts (`cfg_dly_count`+1) times the unit length. Unit code 0 gives 1 clock, code 1 gives 10, code 2 gives 100 and code 3 gives 1000. `conv_req` rises exactly that many clock edges after the edge that accepts `start`.
- R4: Slot i of `cfg_list` occupies bits [3i+2:3i]. During conversion number k of a pass, `conv_chan` equals slot k.
- R5: Each FIFO word holds the channel number in bits [14:12] and the converter code in bits [11:0]. Words are read out in the order they were written.
- R6: With `cfg_continuous` at 0, a run performs exactly `cfg_last_slot`+1 conversions and then drops `busy`.
- R7: With `cfg_continuous` at 1, the slot after `cfg_last_slot` is slot 0, and the run continues until it is stopped.
- R8: A `stop` pulse, or `cfg_enable` going low, ends a settling wait at the next edge. During a conversion it keeps `busy` and `conv_req` high until `conv_ack`, and that result is discarded. When `stop` and `start` arrive in the same cycle, `stop` wins.
- R9: The FIFO holds 32 words. `fifo_count` (6 bits) gives the occupancy, and `fifo_full` and `fifo_empty` follow it.
- R10: A result that arrives while the FIFO is full is dropped and sets `fifo_overflow`. The flag stays set until a `start` pulse is accepted.
- R11: While the FIFO is empty, `rd_data` reads 0, and a `rd_en` pulse leaves `fifo_count` at 0.
- R12: `irq` is 1 exactly when `cfg_irq_en` is 1 and `fifo_count` is at or above `cfg_irq_level`.
- R13: When a result is written and a word is read in the same cycle, `fifo_count` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Engine enable level |
| cfg_continuous | input | 1 | Wrap to slot 0 after the last slot |
| cfg_irq_en | input | 1 | Interrupt enable |
| start | input | 1 | One-cycle run start pulse |
| stop | input | 1 | One-cycle run stop pulse |
| cfg_list | input | 24 | Eight 3-bit channel slots |
| cfg_last_slot | input | 3 | Index of the last active slot |
| cfg_irq_level | input | 5 | Occupancy threshold for `irq` |
| cfg_dly_count | input | 8 | Settling wait length in units, minus one |
| cfg_dly_unit | input | 2 | Unit length select |
| conv_req | output | 1 | Conversion request, held until acknowledged |
| conv_chan | output | 3 | Channel to convert |
| conv_ack | input | 1 | Converter result valid |
| conv_code | input | 12 | Converter result code |
| rd_en | input | 1 | FIFO pop strobe |
| rd_data | output | 15 | Head FIFO word, 0 when empty |
| fifo_count | output | 6 | FIFO occupancy |
| fifo_full | output | 1 | FIFO holds 32 words |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_overflow | output | 1 | Sticky flag for a dropped result |
| busy | output | 1 | A run or a drain is in progress |
| irq | output | 1 | Occupancy interrupt |

## Verification
Two pairs of events can fall in the same cycle. A converter acknowledge can coincide with a FIFO pop, and a stop pulse can coincide with a start pulse or with an outstanding conversion. The bench forces the first pair by raising `conv_ack` and `rd_en` on the same falling edge while the FIFO is partly filled, and then expects `fifo_count` to be unchanged. For the second pair, it drives both pulses together and expects the block to stay idle; it also stops during a held request and expects `busy` to remain high until a manual acknowledge, with no word added. Random channel lists, pass lengths and converter latencies from a fixed seed cover the ordering and tagging paths, and the results are compared with a queue the bench fills as its converter model answers.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_CONV  = 2'd2,
      ST_DRAIN = 2'd3
   } seq_state_e;

   // integer power used to build the delay unit table at elaboration
   function automatic int unsigned ipow(input int unsigned base, input int unsigned exp);
      int unsigned r;
      r = 1;
      for (int unsigned i = 0; i < exp; i++) r = r * base;
      return r;
   endfunction

endpackage

// File: rtl/adc_seq_delay.sv
module adc_seq_delay
   import adc_seq_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int SEL_W = 2,
   parameter int RADIX = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] count,
   input  logic [SEL_W-1:0] unit_sel,
   output logic             done
);
   localparam int NSEL     = 2 ** SEL_W;
   localparam int MAX_UNIT = ipow(RADIX, NSEL - 1);
   localparam int TICK_W   = (MAX_UNIT > 1) ? $clog2(MAX_UNIT) : 1;

   initial begin : prm_chk
      assert (RADIX >= 2) else $error("RADIX must be at least 2");
      assert (CNT_W >= 1 && SEL_W >= 1) else $error("delay field widths must be positive");
   end

   logic [TICK_W-1:0] unit_last [NSEL];
   for (genvar g = 0; g < NSEL; g++) begin : g_unit
      assign unit_last[g] = TICK_W'(ipow(RADIX, g) - 1);
   end

   logic [TICK_W-1:0] tick_q;
   logic [CNT_W-1:0]  units_q;
   logic [TICK_W-1:0] cur_last;
   logic              unit_end;

   assign cur_last = unit_last[unit_sel];
   assign unit_end = (tick_q == cur_last);
   assign done     = run && unit_end && (units_q == count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q  <= '0;
         units_q <= '0;
      end else if (!run) begin
         tick_q  <= '0;
         units_q <= '0;
      end else if (unit_end) begin
         tick_q  <= '0;
         units_q <= units_q + 1'b1;
      end else begin
         tick_q  <= tick_q + 1'b1;
      end
   end

   // R3
   dly_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (tick_q == '0 && units_q == '0));

endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
   parameter int DATA_W = 15,
   parameter int DEPTH  = 32,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              ovf_clr,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty,
   output logic              overflow
);
   initial begin : prm_chk
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wp_q, rp_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              wr_ok, rd_ok;

   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign count   = cnt_q;
   assign wr_ok   = wr_en && !full;
   assign rd_ok   = rd_en && !empty;
   assign rd_data = empty ? '0 : mem[rp_q];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q     <= '0;
         rp_q     <= '0;
         cnt_q    <= '0;
         overflow <= 1'b0;
      end else begin
         if (wr_ok) wp_q <= wp_q + 1'b1;
         if (rd_ok) rp_q <= rp_q + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         if (ovf_clr)            overflow <= 1'b0;
         else if (wr_en && full) overflow <= 1'b1;
      end
   end

   // R9
   occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));

   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !ovf_clr) |=> overflow);

   // R11
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_en && !wr_en) |=> empty);

   // R13
   pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && !full && !empty) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int NUM_ENT = 8,
   parameter int CH_W    = 3,
   parameter int CODE_W  = 12,
   localparam int IDX_W  = $clog2(NUM_ENT),
   localparam int LIST_W = NUM_ENT * CH_W,
   localparam int WORD_W = CH_W + CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              continuous,
   input  logic              start,
   input  logic              stop,
   input  logic [LIST_W-1:0] list,
   input  logic [IDX_W-1:0]  last_idx,
   input  logic              dly_done,
   input  logic              conv_ack,
   input  logic [CODE_W-1:0] conv_code,
   output logic              dly_run,
   output logic              conv_req,
   output logic [CH_W-1:0]   conv_chan,
   output logic              push,
   output logic [WORD_W-1:0] push_word,
   output logic              busy,
   output logic              run_start
);
   initial begin : prm_chk
      assert (NUM_ENT >= 2 && (NUM_ENT & (NUM_ENT - 1)) == 0)
         else $error("NUM_ENT must be a power of two, at least 2");
   end

   logic [CH_W-1:0] slot [NUM_ENT];
   for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
      assign slot[g] = list[g*CH_W +: CH_W];
   end

   seq_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic             halt;
   logic             last;

   assign halt      = stop || !enable;
   assign last      = (idx_q == last_idx);
   assign run_start = (state_q == ST_IDLE) && start && !halt;
   assign busy      = (state_q != ST_IDLE);
   assign dly_run   = (state_q == ST_WAIT);
   assign conv_req  = (state_q == ST_CONV) || (state_q == ST_DRAIN);
   assign conv_chan = slot[idx_q];
   assign push      = (state_q == ST_CONV) && conv_ack && !halt;
   assign push_word = {conv_chan, conv_code};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (run_start) begin
               state_q <= ST_WAIT;
               idx_q   <= '0;
            end
            ST_WAIT: begin
               if (halt)          state_q <= ST_IDLE;
               else if (dly_done) state_q <= ST_CONV;
            end
            ST_CONV: begin
               if (halt) begin
                  state_q <= conv_ack ? ST_IDLE : ST_DRAIN;
               end else if (conv_ack) begin
                  if (!last) begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= ST_WAIT;
                  end else if (continuous) begin
                     idx_q   <= '0;
                     state_q <= ST_WAIT;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            ST_DRAIN: if (conv_ack) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_ack) |=> (conv_req && $stable(conv_chan)));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !run_start) |=> !busy);

   // R7
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && last && continuous) |=> (idx_q == '0 && dly_run));

   // R6
   single_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && last && !continuous) |=> !busy);

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
   parameter int NUM_ENT    = 8,
   parameter int CH_W       = 3,
   parameter int CODE_W     = 12,
   parameter int FIFO_DEPTH = 32,
   parameter int DLY_CNT_W  = 8,
   parameter int DLY_SEL_W  = 2,
   parameter int DLY_RADIX  = 10,
   localparam int IDX_W     = $clog2(NUM_ENT),
   localparam int LIST_W    = NUM_ENT * CH_W,
   localparam int WORD_W    = CH_W + CODE_W,
   localparam int LVL_W     = $clog2(FIFO_DEPTH),
   localparam int CNT_W     = LVL_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic              cfg_continuous,
   input  logic              cfg_irq_en,
   input  logic              start,
   input  logic              stop,
   input  logic [LIST_W-1:0] cfg_list,
   input  logic [IDX_W-1:0]  cfg_last_slot,
   input  logic [LVL_W-1:0]  cfg_irq_level,
   input  logic [DLY_CNT_W-1:0] cfg_dly_count,
   input  logic [DLY_SEL_W-1:0] cfg_dly_unit,
   output logic              conv_req,
   output logic [CH_W-1:0]   conv_chan,
   input  logic              conv_ack,
   input  logic [CODE_W-1:0] conv_code,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic [CNT_W-1:0]  fifo_count,
   output logic              fifo_full,
   output logic              fifo_empty,
   output logic              fifo_overflow,
   output logic              busy,
   output logic              irq
);
   logic              dly_run, dly_done, push, run_start;
   logic [WORD_W-1:0] push_word;

   adc_seq_ctrl #(.NUM_ENT(NUM_ENT), .CH_W(CH_W), .CODE_W(CODE_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .enable(cfg_enable), .continuous(cfg_continuous),
      .start(start), .stop(stop),
      .list(cfg_list), .last_idx(cfg_last_slot),
      .dly_done(dly_done), .conv_ack(conv_ack), .conv_code(conv_code),
      .dly_run(dly_run), .conv_req(conv_req), .conv_chan(conv_chan),
      .push(push), .push_word(push_word), .busy(busy), .run_start(run_start)
   );

   adc_seq_delay #(.CNT_W(DLY_CNT_W), .SEL_W(DLY_SEL_W), .RADIX(DLY_RADIX)) u_delay (
      .clk(clk), .rst_n(rst_n), .run(dly_run),
      .count(cfg_dly_count), .unit_sel(cfg_dly_unit), .done(dly_done)
   );

   adc_seq_fifo #(.DATA_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_en(push), .wr_data(push_word), .rd_en(rd_en), .ovf_clr(run_start),
      .rd_data(rd_data), .count(fifo_count),
      .full(fifo_full), .empty(fifo_empty), .overflow(fifo_overflow)
   );

   assign irq = cfg_irq_en && (fifo_count >= {1'b0, cfg_irq_level});

   // R12
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_irq_en) |-> !irq);

   // R6
   no_push_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy) |=> (fifo_count <= $past(fifo_count)));

endmodule

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b0, cfg_continuous = 1'b0, cfg_irq_en = 1'b0;
   logic        start = 1'b0, stop = 1'b0;
   logic [23:0] cfg_list = '0;
   logic [2:0]  cfg_last_slot = '0;
   logic [4:0]  cfg_irq_level = '0;
   logic [7:0]  cfg_dly_count = '0;
   logic [1:0]  cfg_dly_unit = '0;
   logic        conv_req;
   logic [2:0]  conv_chan;
   logic        conv_ack = 1'b0;
   logic [11:0] conv_code = '0;
   logic        rd_en = 1'b0;
   logic [14:0] rd_data;
   logic [5:0]  fifo_count;
   logic        fifo_full, fifo_empty, fifo_overflow, busy, irq;

   int errors = 0;
   int checks = 0;
   bit auto_conv = 1'b0;
   bit model_ack = 1'b0;
   int lat_left = 0;
   logic [14:0] exp_q[$];

   always #2 clk = ~clk;

   adc_seq_top u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_enable(cfg_enable), .cfg_continuous(cfg_continuous), .cfg_irq_en(cfg_irq_en),
      .start(start), .stop(stop), .cfg_list(cfg_list), .cfg_last_slot(cfg_last_slot),
      .cfg_irq_level(cfg_irq_level), .cfg_dly_count(cfg_dly_count), .cfg_dly_unit(cfg_dly_unit),
      .conv_req(conv_req), .conv_chan(conv_chan), .conv_ack(conv_ack), .conv_code(conv_code),
      .rd_en(rd_en), .rd_data(rd_data), .fifo_count(fifo_count),
      .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_overflow(fifo_overflow),
      .busy(busy), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // converter model: answers after a random latency with a random code
   initial begin
      forever begin
         @(negedge clk);
         if (model_ack) begin
            conv_ack  = 1'b0;
            model_ack = 1'b0;
         end else if (auto_conv && conv_req) begin
            if (lat_left == 0) begin
               conv_code = 12'($urandom);
               conv_ack  = 1'b1;
               model_ack = 1'b1;
               exp_q.push_back({conv_chan, conv_code});
               lat_left  = $urandom_range(0, 3);
            end else begin
               lat_left--;
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   function automatic logic [2:0] slot_of(input logic [23:0] l, input int i);
      return l[3*i +: 3];
   endfunction

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk); stop = 1'b1;
      @(negedge clk); stop = 1'b0;
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 20000 && busy; n++) @(negedge clk);
   endtask

   task automatic pop(output logic [14:0] w);
      @(negedge clk); w = rd_data; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic drain();
      logic [14:0] w;
      while (!fifo_empty) pop(w);
      exp_q.delete();
   endtask

   task automatic run_delay(input logic [1:0] u, input logic [7:0] c);
      int n;
      int unit;
      unit = (u == 0) ? 1 : (u == 1) ? 10 : (u == 2) ? 100 : 1000;
      cfg_dly_unit = u; cfg_dly_count = c; cfg_last_slot = 0; cfg_continuous = 0;
      auto_conv = 1;
      pulse_start();
      n = 0;
      while (!conv_req && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk("R3 delay", n, (int'(c) + 1) * unit);
      wait_idle();
      drain();
   endtask

   task automatic single_pass(input logic [23:0] l, input logic [2:0] lst);
      logic [14:0] w;
      int sz;
      cfg_list = l; cfg_last_slot = lst; cfg_continuous = 0;
      cfg_dly_unit = 2'($urandom_range(0, 1)); cfg_dly_count = 8'($urandom_range(0, 3));
      auto_conv = 1;
      pulse_start();
      wait_idle();
      chk("R6 count", fifo_count, int'(lst) + 1);
      sz = exp_q.size();
      for (int k = 0; k <= int'(lst); k++) begin
         pop(w);
         chk("R4 channel", w[14:12], slot_of(l, k));
         chk("R5 word", w, (k < sz) ? exp_q[k] : 0);
      end
      exp_q.delete();
   endtask

   initial begin
      logic [14:0] w;
      logic [23:0] l;
      int c0;
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 req", conv_req, 0);
      chk("R1 irq", irq, 0);
      chk("R1 empty", fifo_empty, 1);
      chk("R1 count", fifo_count, 0);
      chk("R1 ovf", fifo_overflow, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // start with enable low is ignored
      pulse_start();
      chk("R2 start without enable", busy, 0);
      cfg_enable = 1'b1;
      cfg_list = 24'hFAC688;

      // settling delay per unit code
      run_delay(0, 0);
      run_delay(0, 7);
      run_delay(1, 2);
      run_delay(2, 1);
      run_delay(3, 1);

      // random single passes
      for (int t = 0; t < 5; t++) begin
         l = 24'($urandom);
         single_pass(l, (t == 0) ? 3'd7 : 3'($urandom));
      end

      // interrupt threshold against an 8-word FIFO
      single_pass(24'($urandom), 3'd7);
      // words were popped; refill to 8
      cfg_list = 24'($urandom); cfg_last_slot = 7; pulse_start(); wait_idle();
      chk("R9 count 8", fifo_count, 8);
      cfg_irq_en = 1'b1;
      for (int t = 0; t < 6; t++) begin
         cfg_irq_level = (t == 0) ? 5'd8 : (t == 1) ? 5'd9 : 5'($urandom);
         @(negedge clk);
         chk("R12 irq level", irq, (8 >= int'(cfg_irq_level)) ? 1 : 0);
      end
      cfg_irq_en = 1'b0; cfg_irq_level = 0;
      @(negedge clk);
      chk("R12 irq disabled", irq, 0);

      // same-cycle write and read
      auto_conv = 0; cfg_last_slot = 0; cfg_dly_unit = 0; cfg_dly_count = 0;
      pulse_start();
      while (!conv_req) @(negedge clk);
      c0 = fifo_count;
      conv_code = 12'h5A5; conv_ack = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      conv_ack = 1'b0; rd_en = 1'b0;
      chk("R13 count same", fifo_count, c0);
      chk("R6 idle after one", busy, 0);
      drain();

      // stop during wait, stop with start, stop during conversion
      cfg_dly_unit = 2; cfg_dly_count = 5; auto_conv = 1;
      pulse_start();
      repeat (10) @(negedge clk);
      pulse_stop();
      chk("R8 stop in wait", busy, 0);
      @(negedge clk); start = 1'b1; stop = 1'b1;
      @(negedge clk); start = 1'b0; stop = 1'b0;
      chk("R8 stop beats start", busy, 0);
      auto_conv = 0; cfg_dly_unit = 0; cfg_dly_count = 0;
      pulse_start();
      while (!conv_req) @(negedge clk);
      pulse_stop();
      chk("R8 drain busy", busy, 1);
      chk("R8 drain req", conv_req, 1);
      conv_code = 12'h123; conv_ack = 1'b1;
      @(negedge clk); conv_ack = 1'b0;
      chk("R8 drain done", busy, 0);
      chk("R8 discarded", fifo_count, 0);

      // continuous wrap
      l = 24'($urandom);
      cfg_list = l; cfg_last_slot = 2; cfg_continuous = 1; auto_conv = 1;
      pulse_start();
      for (int n = 0; n < 5000 && fifo_count < 7; n++) @(negedge clk);
      pulse_stop();
      wait_idle();
      for (int k = 0; k < 7; k++) begin
         pop(w);
         chk("R7 wrap channel", w[14:12], slot_of(l, k % 3));
         chk("R5 order", w, exp_q[k]);
      end
      drain();

      // overflow
      cfg_last_slot = 7; cfg_list = 24'($urandom);
      pulse_start();
      for (int n = 0; n < 5000 && !fifo_full; n++) @(negedge clk);
      repeat (40) @(negedge clk);
      chk("R10 ovf set", fifo_overflow, 1);
      pulse_stop();
      wait_idle();
      chk("R9 full count", fifo_count, 32);
      chk("R9 full", fifo_full, 1);
      chk("R9 not empty", fifo_empty, 0);
      cfg_irq_en = 1'b1; cfg_irq_level = 5'd31;
      @(negedge clk);
      chk("R12 irq full", irq, 1);
      cfg_irq_en = 1'b0;
      for (int k = 0; k < 32; k++) begin
         pop(w);
         chk("R10 kept words", w, exp_q[k]);
      end
      exp_q.delete();
      chk("R9 empty", fifo_empty, 1);
      chk("R11 empty data", rd_data, 0);
      pop(w);
      chk("R11 empty pop data", w, 0);
      chk("R11 empty pop count", fifo_count, 0);
      chk("R10 ovf sticky", fifo_overflow, 1);
      cfg_continuous = 0; cfg_last_slot = 0;
      pulse_start();
      chk("R10 ovf cleared", fifo_overflow, 0);
      wait_idle();
      drain();

      summary();
   end
endmodule